// File: doc/BRIEF.md
# GPI Event Generator

This block watches the general-purpose input lines of a keypad controller: eight row lines and ten column lines, eighteen pins in all. Each pin has a programmable active level. A per-pin detector first waits for the pin to reach its active level, which is logged as a press. The detector then re-arms itself for the opposite level, so the return to the inactive level is caught and logged as a release without any polling. Pins enabled for the key event table turn each detection into an 8-bit event word on a push port that feeds the controller's event queue. The low seven bits carry a fixed pin code from 97 to 114, and bit 7 marks press or release.

Detections that cannot be pushed at once wait in a per-pin pending map. One word is pushed per cycle. Events from selected pins can be held back while the keypad is locked. Alongside the event path, each pin keeps an interrupt status bit. These bits feed a sticky aggregate interrupt flag that the host clears by writing one. The status bits themselves clear only after two read strobes.

Top module: `gpi_event_gen`

## Requirements
- R1: With `cfg_level[i]`=1 a pin is pressed when `pin_in[i]` is high; with `cfg_level[i]`=0 it is pressed when `pin_in[i]` is low.
- R2: The event word's bits [6:0] hold 97 plus the pin index: rows 0..7 give 97..104 and columns (pins 8..17) give 105..114.
- R3: After a press is detected, that pin's detector watches the opposite level, and the pin's return to the inactive level is logged as a release.
- R4: Bit 7 of the event word is 1 for a press and 0 for a release.
- R5: A pin with `cfg_evt_en[i]`=0 pushes no event; its detector and status bit still operate.
- R6: While `kp_locked`=1 and `cfg_lock_gate`=1, a pin with `cfg_lock_mask[i]`=1 pushes no event. With `cfg_lock_gate`=0 or an unmasked pin, events are pushed as usual.
- R7: Each press or release detection sets `istat[i]` when `cfg_irq_en[i]`=1, and leaves it unchanged when `cfg_irq_en[i]`=0.
- R8: `gpi_irq` is set by any cycle that sets a status bit and is cleared by an `irq_clr` strobe; a new status set in the same cycle wins.
- R9: The first `istat_rd` strobe leaves `istat` unchanged; the second clears all bits not being set in that cycle.
- R10: `evt_valid` is a one-cycle pulse per event word. It appears on the second rising edge after the pin change. When several words wait, the lowest pin index goes first, and for one pin the press precedes its release.
- R11: After reset, `evt_valid`, `istat` and `gpi_irq` are 0 and every detector waits for its programmed press level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 18 | Synchronized pin levels (bits 0..7 rows, 8..17 columns) |
| cfg_level | input | 18 | Active level per pin (1 = high is press) |
| cfg_evt_en | input | 18 | Pin produces event words |
| cfg_irq_en | input | 18 | Pin sets its status bit |
| cfg_lock_mask | input | 18 | Pin is silenced while locked |
| cfg_lock_gate | input | 1 | Global enable of lock silencing |
| kp_locked | input | 1 | Keypad is locked |
| istat_rd | input | 1 | Status read strobe |
| irq_clr | input | 1 | Write-one clear of the aggregate flag |
| evt_valid | output | 1 | Event word push strobe |
| evt_code | output | 8 | Event word: bit 7 press, bits 6..0 code |
| istat | output | 18 | Per-pin interrupt status |
| gpi_irq | output | 1 | Aggregate GPI interrupt flag |

## Verification
Slow press and release on single pins with both polarities show that the level bit and the re-arming work. They also fix the code and bit-7 values, and the exact push latency. Two pins rising together, and two pins pulsed for a single cycle, fill the pending map. These runs separate lowest-index-first order from per-pin press-before-release order. Toggles on a disabled pin, a locked and masked pin, and a pin with interrupt disabled show that the event and status paths are gated independently. Single and double read strobes tell the two-read clear apart from a one-read clear.

// File: rtl/gpi_evt_pkg.sv
package gpi_evt_pkg;
    localparam int GPI_ROWS  = 8;
    localparam int GPI_COLS  = 10;
    localparam int CODE_BASE = 97;

    typedef struct packed {
        logic       press;
        logic [6:0] code;
    } gpi_evt_t;

    function automatic gpi_evt_t evt_word(input int idx, input logic press);
        gpi_evt_t w;
        w.press = press;
        w.code  = 7'(CODE_BASE + idx);
        return w;
    endfunction
endpackage

// File: rtl/gpi_pin_detector.sv
module gpi_pin_detector (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic level,
    input  logic stall,
    output logic watch_press,
    output logic hit_acc
);
    logic target;
    logic hit;

    assign target  = watch_press ? level : ~level;
    assign hit     = (pin == target);
    assign hit_acc = hit & ~stall;

    always_ff @(posedge clk) begin
        if (rst)          watch_press <= 1'b1;
        else if (hit_acc) watch_press <= ~watch_press;
    end

    // R3: an accepted detection flips the watched level
    p_rearm_r3: assert property (@(posedge clk) disable iff (rst)
        hit_acc |=> (watch_press != $past(watch_press)));
endmodule

// File: rtl/gpi_event_arbiter.sv
module gpi_event_arbiter
    import gpi_evt_pkg::*;
#(
    parameter int NPIN = GPI_ROWS + GPI_COLS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] set_press,
    input  logic [NPIN-1:0] set_rel,
    output logic [NPIN-1:0] press_pend,
    output logic [NPIN-1:0] rel_pend,
    output logic            evt_valid,
    output gpi_evt_t        evt_code
);
    localparam int IDX_W = $clog2(NPIN);

    logic             gnt_valid;
    logic             gnt_press;
    logic [IDX_W-1:0] gnt_idx;
    logic [NPIN-1:0]  gnt_hot;

    always_comb begin
        gnt_valid = 1'b0;
        gnt_press = 1'b0;
        gnt_idx   = '0;
        for (int i = NPIN - 1; i >= 0; i--) begin
            if (press_pend[i] | rel_pend[i]) begin
                gnt_valid = 1'b1;
                gnt_press = press_pend[i];
                gnt_idx   = IDX_W'(i);
            end
        end
    end

    assign gnt_hot = gnt_valid ? (NPIN'(1) << gnt_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            press_pend <= '0;
            rel_pend   <= '0;
            evt_valid  <= 1'b0;
            evt_code   <= '0;
        end else begin
            press_pend <= (press_pend & ~(gnt_hot & {NPIN{gnt_press}}))  | set_press;
            rel_pend   <= (rel_pend   & ~(gnt_hot & {NPIN{~gnt_press}})) | set_rel;
            evt_valid  <= gnt_valid;
            evt_code   <= gnt_valid ? evt_word(int'(gnt_idx), gnt_press) : '0;
        end
    end

    p_code_range_r2: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (int'(evt_code.code) >= CODE_BASE &&
                       int'(evt_code.code) <  CODE_BASE + NPIN));

    p_push_from_pending_r10: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> $past(|(press_pend | rel_pend)));

    p_press_first_r10: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && !gnt_press) |-> !press_pend[gnt_idx]);
endmodule

// File: rtl/gpi_irq_status.sv
module gpi_irq_status #(
    parameter int NPIN = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] det,
    input  logic [NPIN-1:0] irq_en,
    input  logic            istat_rd,
    input  logic            irq_clr,
    output logic [NPIN-1:0] istat,
    output logic            gpi_irq
);
    logic [NPIN-1:0] set_v;
    logic            rd_half;
    logic            rd_done;

    assign set_v   = det & irq_en;
    assign rd_done = istat_rd & rd_half;

    always_ff @(posedge clk) begin
        if (rst) begin
            istat   <= '0;
            rd_half <= 1'b0;
            gpi_irq <= 1'b0;
        end else begin
            if (istat_rd) rd_half <= ~rd_half;
            istat   <= (rd_done ? '0 : istat) | set_v;
            gpi_irq <= (|set_v) | (gpi_irq & ~irq_clr);
        end
    end

    p_first_read_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (istat_rd && !rd_half) |=> ((istat & $past(istat)) == $past(istat)));

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !(|set_v)) |=> !gpi_irq);

    p_istat_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
        (istat & ~$past(istat) & ~$past(irq_en)) == '0);
endmodule

// File: rtl/gpi_event_gen.sv
module gpi_event_gen
    import gpi_evt_pkg::*;
#(
    parameter int N_ROW = GPI_ROWS,
    parameter int N_COL = GPI_COLS,
    localparam int NPIN = N_ROW + N_COL
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pin_in,
    input  logic [NPIN-1:0] cfg_level,
    input  logic [NPIN-1:0] cfg_evt_en,
    input  logic [NPIN-1:0] cfg_irq_en,
    input  logic [NPIN-1:0] cfg_lock_mask,
    input  logic            cfg_lock_gate,
    input  logic            kp_locked,
    input  logic            istat_rd,
    input  logic            irq_clr,
    output logic            evt_valid,
    output logic [7:0]      evt_code,
    output logic [NPIN-1:0] istat,
    output logic            gpi_irq
);
    logic [NPIN-1:0] watch_press;
    logic [NPIN-1:0] hit_acc;
    logic [NPIN-1:0] stall;
    logic [NPIN-1:0] record;
    logic [NPIN-1:0] press_pend;
    logic [NPIN-1:0] rel_pend;
    logic [NPIN-1:0] set_press;
    logic [NPIN-1:0] set_rel;
    gpi_evt_t        evt_word_q;

    // a press waits while any word of its pin is pending; a release waits only on a pending release
    assign stall  = (watch_press & (press_pend | rel_pend)) | (~watch_press & rel_pend);
    assign record = cfg_evt_en & ~({NPIN{kp_locked & cfg_lock_gate}} & cfg_lock_mask);
    assign set_press = hit_acc &  watch_press & record;
    assign set_rel   = hit_acc & ~watch_press & record;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        gpi_pin_detector u_det (
            .clk         (clk),
            .rst         (rst),
            .pin         (pin_in[g]),
            .level       (cfg_level[g]),
            .stall       (stall[g]),
            .watch_press (watch_press[g]),
            .hit_acc     (hit_acc[g])
        );
    end

    gpi_event_arbiter #(.NPIN(NPIN)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .set_press  (set_press),
        .set_rel    (set_rel),
        .press_pend (press_pend),
        .rel_pend   (rel_pend),
        .evt_valid  (evt_valid),
        .evt_code   (evt_word_q)
    );

    assign evt_code = evt_word_q;

    gpi_irq_status #(.NPIN(NPIN)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .det      (hit_acc),
        .irq_en   (cfg_irq_en),
        .istat_rd (istat_rd),
        .irq_clr  (irq_clr),
        .istat    (istat),
        .gpi_irq  (gpi_irq)
    );

    // R5 / R6: a pin that may not record never gains a pending word
    p_gate_r5: assert property (@(posedge clk) disable iff (rst)
        ((press_pend | rel_pend) & ~$past(press_pend | rel_pend) & ~$past(record)) == '0);
endmodule

// File: tb/gpi_event_gen_tb.sv
module gpi_event_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NPIN = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NPIN-1:0] pin_in, cfg_level, cfg_evt_en, cfg_irq_en, cfg_lock_mask;
    logic cfg_lock_gate, kp_locked, istat_rd, irq_clr;
    logic evt_valid, gpi_irq;
    logic [7:0] evt_code;
    logic [NPIN-1:0] istat;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpi_event_gen u_dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cfg_level(cfg_level),
        .cfg_evt_en(cfg_evt_en), .cfg_irq_en(cfg_irq_en),
        .cfg_lock_mask(cfg_lock_mask), .cfg_lock_gate(cfg_lock_gate),
        .kp_locked(kp_locked), .istat_rd(istat_rd), .irq_clr(irq_clr),
        .evt_valid(evt_valid), .evt_code(evt_code), .istat(istat), .gpi_irq(gpi_irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_evt(input bit press, input int idx);
        exp_q.push_back({press, 7'(97 + idx)});
    endtask

    task automatic drain(input string req);
        for (int k = 0; k < 60 && exp_q.size() != 0; k++) tick(1);
        tick(4);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && evt_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5/R6 unexpected event actual=0x%0h expected=none", evt_code);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (evt_code !== e) begin
                    errors++;
                    $display("FAIL R2/R4/R10 event actual=0x%0h expected=0x%0h", evt_code, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cfg_level     = '1;
        cfg_level[3]  = 1'b0;
        cfg_level[12] = 1'b0;
        pin_in        = '0;
        pin_in[3]     = 1'b1;
        pin_in[12]    = 1'b1;
        cfg_evt_en    = '1;
        cfg_evt_en[6] = 1'b0;
        cfg_irq_en    = '1;
        cfg_irq_en[7] = 1'b0;
        cfg_lock_mask = '0;
        cfg_lock_mask[1] = 1'b1;
        cfg_lock_gate = 1'b1;
        kp_locked = 1'b0;
        istat_rd = 1'b0;
        irq_clr = 1'b0;
        tick(4);
        rst = 1'b0;
        tick(3);
        // R11 reset state, no spurious events with pins at inactive level
        check(evt_valid == 1'b0, "R11 evt_valid", evt_valid, 0);
        check(istat == '0, "R11 istat", istat, 0);
        check(gpi_irq == 1'b0, "R11 gpi_irq", gpi_irq, 0);

        // R1 active high, R10 latency, R4 press flag, R2 row code
        expect_evt(1, 0);
        pin_in[0] = 1'b1;
        tick(1);
        check(evt_valid == 1'b0, "R10 latency first edge", evt_valid, 0);
        tick(1);
        check(evt_valid == 1'b1, "R10 latency second edge", evt_valid, 1);
        tick(1);
        check(evt_valid == 1'b0, "R10 single pulse", evt_valid, 0);
        // R3 release after re-arm
        expect_evt(0, 0);
        pin_in[0] = 1'b0;
        drain("R3 release row0");

        // R1 active low on column pin 12 (code 109)
        expect_evt(1, 12);
        pin_in[12] = 1'b0;
        drain("R1 active-low press");
        expect_evt(0, 12);
        pin_in[12] = 1'b1;
        drain("R3 active-low release");

        // R10 lowest index first, R2 top column code 114
        expect_evt(1, 5);
        expect_evt(1, 17);
        pin_in[5] = 1'b1;
        pin_in[17] = 1'b1;
        drain("R10 simultaneous press order");
        expect_evt(0, 5);
        expect_evt(0, 17);
        pin_in[5] = 1'b0;
        pin_in[17] = 1'b0;
        drain("R10 simultaneous release order");

        // R10 one-cycle pulses on two pins: press before release per pin
        expect_evt(1, 2);
        expect_evt(0, 2);
        expect_evt(1, 9);
        expect_evt(0, 9);
        pin_in[2] = 1'b1;
        pin_in[9] = 1'b1;
        tick(1);
        pin_in[2] = 1'b0;
        pin_in[9] = 1'b0;
        drain("R10 pulse ordering");

        // R6 locked and masked pin is silent, unmasked pin still reports
        kp_locked = 1'b1;
        pin_in[1] = 1'b1;
        tick(3);
        pin_in[1] = 1'b0;
        drain("R6 masked pin silent");
        expect_evt(1, 4);
        expect_evt(0, 4);
        pin_in[4] = 1'b1;
        tick(3);
        pin_in[4] = 1'b0;
        drain("R6 unmasked pin reports");
        cfg_lock_gate = 1'b0;
        expect_evt(1, 1);
        expect_evt(0, 1);
        pin_in[1] = 1'b1;
        tick(3);
        pin_in[1] = 1'b0;
        drain("R6 gate cleared reports");
        kp_locked = 1'b0;

        // clear status with two reads, clear flag
        istat_rd = 1'b1; tick(1); istat_rd = 1'b0; tick(1);
        istat_rd = 1'b1; tick(1); istat_rd = 1'b0; tick(1);
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(1);
        check(istat == '0, "R9 two reads clear", istat, 0);
        check(gpi_irq == 1'b0, "R8 write-one clear", gpi_irq, 0);

        // R5 disabled pin: no event, status still set (R7)
        pin_in[6] = 1'b1;
        tick(3);
        check(istat == 18'(1 << 6), "R7 status from disabled pin", istat, 18'(1 << 6));
        check(gpi_irq == 1'b1, "R8 flag set", gpi_irq, 1);
        pin_in[6] = 1'b0;
        drain("R5 disabled pin silent");

        // R7 irq-disabled pin leaves status alone
        expect_evt(1, 7);
        expect_evt(0, 7);
        pin_in[7] = 1'b1;
        tick(3);
        pin_in[7] = 1'b0;
        drain("R7 irq-disabled events");
        check(istat == 18'(1 << 6), "R7 status unchanged", istat, 18'(1 << 6));

        // R9 first read keeps, second clears
        istat_rd = 1'b1; tick(1); istat_rd = 1'b0; tick(1);
        check(istat == 18'(1 << 6), "R9 first read keeps", istat, 18'(1 << 6));
        istat_rd = 1'b1; tick(1); istat_rd = 1'b0; tick(1);
        check(istat == '0, "R9 second read clears", istat, 0);
        check(gpi_irq == 1'b1, "R8 flag survives reads", gpi_irq, 1);
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(1);
        check(gpi_irq == 1'b0, "R8 cleared by write", gpi_irq, 0);

        tick(5);
        check(exp_q.size() == 0, "R10 scoreboard empty", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule